// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

The block holds four 64-bit down-counters behind a simple 32-bit register bus. Every counter has its own control word, prescaler and mode. A counter in one-shot mode starts when its enable bit goes from 0 to 1. A counter in hardware-trigger mode stays idle until the previous counter in the ring signals end of count, and it then reloads its initial value and starts counting. A 4-bit select register picks the counter whose expiry raises the registered watchdog reset pulse.

The intended use chains two counters. A one-shot counter is loaded with zero and acts as a kick source. The next counter, in hardware-trigger mode, is the watchdog. Software kicks the watchdog by clearing and then setting the kick counter's enable bit. That raises an end-count event at once, and the event reloads the watchdog counter without ever stopping it. The 64-bit count is read as two words. Reading the low word captures the high word, so the pair forms one consistent snapshot.

Top module: `cwd_bank`

## Requirements
- R1: After reset, every control word, count, reload value, capture register and the select register are 0, `wdogRst` is 0 and `busRdData` is 0.
- R2: A read returns its data on `busRdData` in the cycle after `busRdEn`, and 0 in any cycle without a read. Counter n's control word sits at address n*0x10, with these fields: bit 0 enable, bit 1 active (read-only), bits [3:2] mode, bits [7:4] trigger source, bits [15:8] prescaler. Bits [31:16] read as 0. The select register at 0x40 keeps 4 bits and its upper bits read as 0. Any other offset in a counter slot reads as 0.
- R3: A write to n*0x10+0x4 sets the low 32 bits of counter n's reload value and of its current count. A write to n*0x10+0x8 sets the high 32 bits of both.
- R4: A read of n*0x10+0x4 returns the low 32 bits of the current count and captures the high 32 bits. A later read of n*0x10+0x8 returns the captured half, even after the count has moved.
- R5: An active counter with a nonzero count decrements once every P clocks, where P is the prescaler field. Values below 2 act as 2. The first decrement comes P clocks after activation.
- R6: In one-shot mode (mode not 3), writing enable from 0 to 1 loads the reload value and sets active. An active counter at count 0 drives end-count for one cycle and then clears active. It does not restart until enable is written from 0 to 1 again.
- R7: In mode 3 with trigger source 5, an enabled counter stays inactive until counter n-1 ends its count (counter 0 follows counter 3). That event reloads the initial value and sets active. Setting enable alone does not activate it.
- R8: `wdogRst` is high for one cycle, in the cycle after a counter whose select bit is set ends its count. With select 0, `wdogRst` stays 0.
- R9: Writing a control word with bit 0 clear stops that counter and clears its active flag.
- R10: With counter 0 in one-shot mode at count 0 and counter 1 in mode 3 with trigger 5, toggling counter 0's enable 0 then 1 reloads counter 1 while it keeps running. Kicks spaced closer than its timeout give no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the read strobe |
| wdogRst | output | 1 | Registered one-cycle watchdog reset pulse |

## Verification
The assertions assume that a read and a write never arrive in the same cycle. They also assume that a count register is never written while its counter is active, so a load never meets a decrement in the same cycle. The stimulus issues one bus access per cycle from tasks. It loads counts only while a counter is disabled or has already expired, and it kicks the watchdog only through the kick counter's enable bit. Coverage comes from a behavioural model that is compared on every clock, from directed reads of the control words and counts, and from a monitor that counts reset pulses during the kick phase and after the kicks stop.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam int CNT_NUM   = 4;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 2 * DATA_W;
  localparam int ADDR_W    = 8;
  localparam int IDX_W     = ADDR_W - 4;
  localparam int PSC_W     = 8;
  localparam int PSC_MIN   = 2;
  localparam logic [1:0] MODE_HW   = 2'b11;
  localparam logic [3:0] TRIG_PREV = 4'd5;
  localparam logic [ADDR_W-1:0] SEL_ADDR = 8'h40;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_LOW  = 4'h4;
  localparam logic [3:0] OFF_HIGH = 4'h8;

  typedef struct packed {
    logic [CNT_NUM-1:0] ctrlWr;
    logic [CNT_NUM-1:0] loWr;
    logic [CNT_NUM-1:0] hiWr;
    logic [CNT_NUM-1:0] loRd;
    logic               selWr;
    logic [DATA_W-1:0]  data;
  } strobe_t;
endpackage

// File: rtl/cwd_ctrl.sv
module cwd_ctrl
  import cwd_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrEn,
  input  logic                            busRdEn,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWrData,
  input  logic [CNT_NUM-1:0][DATA_W-1:0]  ctrlWords,
  input  logic [CNT_NUM-1:0][DATA_W-1:0]  cntLow,
  input  logic [CNT_NUM-1:0][DATA_W-1:0]  holdHi,
  input  logic [CNT_NUM-1:0]              selVal,
  output strobe_t                         stb,
  output logic [DATA_W-1:0]               busRdData
);
  logic [IDX_W-1:0]  idx;
  logic [3:0]        off;
  logic [DATA_W-1:0] rdNext;

  assign idx = busAddr[ADDR_W-1:4];
  assign off = busAddr[3:0];

  // Address decode into per-counter strobes
  always_comb begin
    stb       = '0;
    stb.data  = busWrData;
    stb.selWr = busWrEn && (busAddr == SEL_ADDR);
    for (int n = 0; n < CNT_NUM; n++) begin
      if (idx == IDX_W'(n)) begin
        stb.ctrlWr[n] = busWrEn && (off == OFF_CTRL);
        stb.loWr[n]   = busWrEn && (off == OFF_LOW);
        stb.hiWr[n]   = busWrEn && (off == OFF_HIGH);
        stb.loRd[n]   = busRdEn && (off == OFF_LOW);
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rdNext = '0;
    if (busRdEn) begin
      if (busAddr == SEL_ADDR)
        rdNext = {{(DATA_W-CNT_NUM){1'b0}}, selVal};
      for (int n = 0; n < CNT_NUM; n++) begin
        if (idx == IDX_W'(n)) begin
          case (off)
            OFF_CTRL: rdNext = ctrlWords[n];
            OFF_LOW:  rdNext = cntLow[n];
            OFF_HIGH: rdNext = holdHi[n];
            default:  rdNext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= rdNext;
  end

  // R2: at most one register is written per cycle
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctrlWr, stb.loWr, stb.hiWr, stb.selWr}));

  // R2: select readback carries no bits above the counter count
  p_sel_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && busAddr == SEL_ADDR) |=> (busRdData[DATA_W-1:CNT_NUM] == '0));
endmodule

// File: rtl/cwd_counter.sv
module cwd_counter
  import cwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              loWr,
  input  logic              hiWr,
  input  logic              loRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              trigIn,
  output logic              endCnt,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] cntLow,
  output logic [DATA_W-1:0] holdHi
);
  logic              enable;
  logic              active;
  logic [1:0]        mode;
  logic [3:0]        trigSrc;
  logic [PSC_W-1:0]  psc;
  logic [PSC_W-1:0]  pscCnt;
  logic [PSC_W-1:0]  effPsc;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  initVal;
  logic [DATA_W-1:0] hold;
  logic              tick;
  logic              trigHit;
  logic              startOne;

  assign effPsc   = (psc < PSC_W'(PSC_MIN)) ? PSC_W'(PSC_MIN) : psc;
  assign tick     = (pscCnt == effPsc - PSC_W'(1));
  assign endCnt   = active && (cnt == '0);
  assign trigHit  = enable && (mode == MODE_HW) && (trigSrc == TRIG_PREV) && trigIn;
  assign startOne = wrData[0] && !enable && (wrData[3:2] != MODE_HW);

  assign ctrlWord = {{(DATA_W-16){1'b0}}, psc, trigSrc, mode, active, enable};
  assign cntLow   = cnt[DATA_W-1:0];
  assign holdHi   = hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      active  <= 1'b0;
      mode    <= '0;
      trigSrc <= '0;
      psc     <= '0;
      pscCnt  <= '0;
      cnt     <= '0;
      initVal <= '0;
      hold    <= '0;
    end else begin
      if (active) begin
        if (cnt == '0) begin
          active <= 1'b0;
        end else if (tick) begin
          cnt    <= cnt - CNT_W'(1);
          pscCnt <= '0;
        end else begin
          pscCnt <= pscCnt + PSC_W'(1);
        end
      end
      if (trigHit) begin
        cnt    <= initVal;
        active <= 1'b1;
        pscCnt <= '0;
      end
      if (ctrlWr) begin
        enable  <= wrData[0];
        mode    <= wrData[3:2];
        trigSrc <= wrData[7:4];
        psc     <= wrData[15:8];
        if (!wrData[0]) begin
          active <= 1'b0;
        end else if (startOne) begin
          cnt    <= initVal;
          active <= 1'b1;
          pscCnt <= '0;
        end
      end
      if (loWr) begin
        initVal[DATA_W-1:0] <= wrData;
        cnt[DATA_W-1:0]     <= wrData;
      end
      if (hiWr) begin
        initVal[CNT_W-1:DATA_W] <= wrData;
        cnt[CNT_W-1:DATA_W]     <= wrData;
      end
      if (loRd) hold <= cnt[CNT_W-1:DATA_W];
    end
  end

  // R6: an end-count without reload or rewrite leaves the counter inactive
  p_end_drops_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    (endCnt && !trigHit && !ctrlWr) |=> !active);

  // R7: a hardware-trigger counter never starts on its own
  p_hw_waits_trigger_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_HW) && !active && !trigHit && !ctrlWr) |=> !active);

  // R5: a running count moves by at most one step per clock
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && cnt != '0 && !trigHit && !ctrlWr && !loWr && !hiWr)
      |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1))));

  // R9: a control write without enable stops the counter
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[0]) |=> (!active && !enable));
endmodule

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  output logic [CNT_NUM-1:0][DATA_W-1:0] ctrlWords,
  output logic [CNT_NUM-1:0][DATA_W-1:0] cntLow,
  output logic [CNT_NUM-1:0][DATA_W-1:0] holdHi,
  output logic [CNT_NUM-1:0]             selVal,
  output logic                           wdogRst
);
  logic [CNT_NUM-1:0] endCnt;
  logic [CNT_NUM-1:0] selReg;

  genvar g;
  generate
    for (g = 0; g < CNT_NUM; g++) begin : gCnt
      cwd_counter uCnt (
        .clk      (clk),
        .rstN     (rstN),
        .ctrlWr   (stb.ctrlWr[g]),
        .loWr     (stb.loWr[g]),
        .hiWr     (stb.hiWr[g]),
        .loRd     (stb.loRd[g]),
        .wrData   (stb.data),
        .trigIn   (endCnt[(g + CNT_NUM - 1) % CNT_NUM]),
        .endCnt   (endCnt[g]),
        .ctrlWord (ctrlWords[g]),
        .cntLow   (cntLow[g]),
        .holdHi   (holdHi[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      wdogRst <= 1'b0;
    end else begin
      if (stb.selWr) selReg <= stb.data[CNT_NUM-1:0];
      wdogRst <= |(endCnt & selReg);
    end
  end

  assign selVal = selReg;

  // R8: with no counter selected the reset output stays low
  p_no_sel_no_rst_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selReg == '0) |=> !wdogRst);
endmodule

// File: rtl/cwd_bank.sv
module cwd_bank
  import cwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              wdogRst
);
  strobe_t                        stb;
  logic [CNT_NUM-1:0][DATA_W-1:0] ctrlWords;
  logic [CNT_NUM-1:0][DATA_W-1:0] cntLow;
  logic [CNT_NUM-1:0][DATA_W-1:0] holdHi;
  logic [CNT_NUM-1:0]             selVal;

  cwd_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .ctrlWords (ctrlWords),
    .cntLow    (cntLow),
    .holdHi    (holdHi),
    .selVal    (selVal),
    .stb       (stb),
    .busRdData (busRdData)
  );

  cwd_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ctrlWords (ctrlWords),
    .cntLow    (cntLow),
    .holdHi    (holdHi),
    .selVal    (selVal),
    .wdogRst   (wdogRst)
  );
endmodule

// File: tb/tb_cwd_bank.sv
`timescale 1ns/100ps
module tb_cwd_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        wdogRst;

  int vectors = 0;
  int errors = 0;
  int rstCycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cwd_bank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .wdogRst(wdogRst)
  );

  // Behavioural reference model
  longint unsigned mCnt[4], mInit[4];
  bit        mEn[4], mAct[4];
  bit [1:0]  mMode[4];
  bit [3:0]  mTrig[4];
  int        mPsc[4], mPcnt[4];
  bit [31:0] mHold[4];
  bit [3:0]  mSel;
  bit        mRst;
  bit [31:0] mRd;
  bit        ec[4];
  bit        tr;
  int        eff;
  int        slot;
  int        offs;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < 4; n++) begin
        mCnt[n] = 0; mInit[n] = 0; mEn[n] = 0; mAct[n] = 0; mMode[n] = 0;
        mTrig[n] = 0; mPsc[n] = 0; mPcnt[n] = 0; mHold[n] = 0;
      end
      mSel = 0; mRst = 0; mRd = 0;
    end else begin
      for (int n = 0; n < 4; n++) ec[n] = mAct[n] && (mCnt[n] == 0);
      mRst = (ec[0] && mSel[0]) || (ec[1] && mSel[1]) || (ec[2] && mSel[2]) || (ec[3] && mSel[3]);
      slot = int'(busAddr[7:4]);
      offs = int'(busAddr[3:0]);
      mRd = 0;
      if (busRdEn) begin
        if (busAddr == 8'h40) mRd = {28'd0, mSel};
        else if (slot < 4) begin
          if (offs == 0)
            mRd = {16'd0, mPsc[slot][7:0], mTrig[slot], mMode[slot], mAct[slot], mEn[slot]};
          else if (offs == 4) begin
            mRd = mCnt[slot][31:0];
            mHold[slot] = mCnt[slot][63:32];
          end else if (offs == 8) mRd = mHold[slot];
        end
      end
      for (int n = 0; n < 4; n++) begin
        tr = mEn[n] && (mMode[n] == 3) && (mTrig[n] == 5) && ec[(n + 3) % 4];
        if (mAct[n]) begin
          if (mCnt[n] == 0) mAct[n] = 0;
          else begin
            eff = (mPsc[n] < 2) ? 2 : mPsc[n];
            if (mPcnt[n] == eff - 1) begin mCnt[n] = mCnt[n] - 1; mPcnt[n] = 0; end
            else mPcnt[n] = mPcnt[n] + 1;
          end
        end
        if (tr) begin mCnt[n] = mInit[n]; mAct[n] = 1; mPcnt[n] = 0; end
        if (busWrEn && slot == n) begin
          if (offs == 0) begin
            if (!busWrData[0]) mAct[n] = 0;
            else if (!mEn[n] && busWrData[3:2] != 2'b11) begin
              mCnt[n] = mInit[n]; mAct[n] = 1; mPcnt[n] = 0;
            end
            mEn[n] = busWrData[0]; mMode[n] = busWrData[3:2];
            mTrig[n] = busWrData[7:4]; mPsc[n] = int'(busWrData[15:8]);
          end else if (offs == 4) begin
            mInit[n] = {mInit[n][63:32], busWrData};
            mCnt[n]  = {mCnt[n][63:32], busWrData};
          end else if (offs == 8) begin
            mInit[n] = {busWrData, mInit[n][31:0]};
            mCnt[n]  = {busWrData, mCnt[n][31:0]};
          end
        end
      end
      if (busWrEn && busAddr == 8'h40) mSel = busWrData[3:0];
    end
  end

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      if (busRdData !== mRd) begin
        errors++;
        $display("FAIL R2 busRdData actual %h expected %h", busRdData, mRd);
      end
      if (wdogRst !== mRst) begin
        errors++;
        $display("FAIL R8 wdogRst actual %b expected %b", wdogRst, mRst);
      end
      if (wdogRst === 1'b1) rstCycles++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    check(tag, busRdData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 wdogRst after reset", {31'd0, wdogRst}, 32'd0);
    rd(8'h00, 32'h0, "R1 ctrl0 after reset");
    rd(8'h40, 32'h0, "R1 select after reset");
    rd(8'h14, 32'h0, "R1 count1 after reset");
    // R2 field layout, reserved bits, read-only active, select width
    wr(8'h20, 32'hFFFF_03F2);
    rd(8'h20, 32'h0000_03F0, "R2 ctrl2 readback");
    rd(8'h3C, 32'h0, "R2 unmapped offset");
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0000_000F, "R2 select width");
    wr(8'h40, 32'h0);
    // R3 count write
    wr(8'h34, 32'h1234_5678);
    wr(8'h38, 32'h9ABC_DEF0);
    rd(8'h34, 32'h1234_5678, "R3 count3 low");
    rd(8'h38, 32'h9ABC_DEF0, "R3 count3 high");
    // R4 snapshot across a borrow
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h1);
    wr(8'h20, 32'h0000_0201);
    rd(8'h24, 32'h0, "R4 low before borrow");
    idle(10);
    rd(8'h28, 32'h1, "R4 captured high");
    wr(8'h20, 32'h0000_0200);
    rd(8'h20, 32'h0000_0200, "R9 disable clears active");
    // R5 prescaler 5
    wr(8'h34, 32'd10);
    wr(8'h38, 32'd0);
    wr(8'h30, 32'h0000_0501);
    idle(11);
    rd(8'h34, 32'd8, "R5 count after prescaled steps");
    // R6 one-shot expiry, no restart, select 0 gives no reset
    idle(60);
    rd(8'h30, 32'h0000_0501, "R6 active cleared after end");
    rd(8'h34, 32'd0, "R6 count stays zero");
    check("R8 no reset with select 0", rstCycles, 0);
    // R7 hardware-trigger counter waits
    wr(8'h00, 32'h0000_0200);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h14, 32'd20);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'h0000_025D);
    wr(8'h40, 32'h2);
    idle(10);
    rd(8'h10, 32'h0000_025D, "R7 enabled but idle");
    rd(8'h14, 32'd20, "R7 count held");
    // R10 kicks keep the watchdog alive
    for (int k = 0; k < 5; k++) begin
      wr(8'h00, 32'h0000_0200);
      wr(8'h00, 32'h0000_0201);
      idle(20);
    end
    rd(8'h10, 32'h0000_025F, "R10 watchdog running");
    check("R10 no reset while kicked", rstCycles, 0);
    // R8 expiry gives one pulse
    idle(60);
    check("R8 single reset pulse", rstCycles, 1);
    rd(8'h10, 32'h0000_025D, "R8 watchdog inactive after expiry");
    // R9 disable, then R7 ring wrap: counter 0 follows counter 3
    wr(8'h10, 32'h0000_025C);
    rd(8'h10, 32'h0000_025C, "R9 watchdog disabled");
    wr(8'h30, 32'h0000_0200);
    wr(8'h34, 32'd0);
    wr(8'h04, 32'd5);
    wr(8'h00, 32'h0000_025D);
    rd(8'h00, 32'h0000_025D, "R7 counter0 idle in trigger mode");
    wr(8'h30, 32'h0000_0201);
    idle(1);
    rd(8'h00, 32'h0000_025F, "R7 counter0 started by counter3");
    idle(20);
    rd(8'h00, 32'h0000_025D, "R7 counter0 ended");
    check("R8 no pulse from unselected counter", rstCycles, 1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule